// File: doc/BRIEF.md
# Branch and Stack Sequencing Unit

This block works out where an 8-bit accumulator processor goes next after a control-transfer opcode. Each strobed opcode brings its own inputs: the 16-bit immediate operand, the address of the opcode, the stack pointer, the HL pair, the four condition flags (sign, zero, parity, carry) and the word that the surrounding datapath has already read from the top of the stack. From these the block picks the next program counter and the next stack pointer. It also raises a one-cycle stack write request with the address and the word to store, or a one-cycle stack read request with the address it consumed. It reports how many cycles the opcode takes beyond its base count.

It handles unconditional and conditional jumps, calls and returns, the eight restart vectors, the register-indirect jump through HL, and four undocumented aliases. The aliases are one extra return, one extra jump and two extra calls. Any other opcode is treated as a plain one-byte step. Instruction fetch, memory and arithmetic stay outside the block. All results are registered and change on the clock edge at which the strobe is sampled high.

Top module: `branch_seq`

## Requirements
- R1: A synchronous reset takes priority over the strobe and clears `pc_q`, `sp_q`, `stk_wr`, `stk_rd` and `extra_cyc` to zero.
- R2: For conditional opcodes, bits 5:3 select the condition: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear, 5 parity set, 6 sign clear, 7 sign set.
- R3: A conditional jump (11ccc010) loads the operand into PC when its condition holds. Otherwise PC becomes opcode address + 3, with no stack request. A conditional call (11ccc100) that is not taken also leaves PC at opcode address + 3 and makes no stack request.
- R4: `extra_cyc` is 6 after a taken conditional call (11ccc100) or a taken conditional return (11ccc000), and 0 after every other opcode, including the same opcodes when not taken.
- R5: A call (0xCD, or a taken 11ccc100) sets SP to SP-2 and writes the opcode address + 3 at the new SP. The low byte goes at SP and the high byte at SP+1. PC then takes the operand.
- R6: A return (0xC9, or a taken 11ccc000) reads the stack at the current SP, loads PC from the popped word and sets SP to SP+2. A return that is not taken gives opcode address + 1.
- R7: A restart (11nnn111) pushes opcode address + 1 as in R5 and jumps to the opcode AND 0x38.
- R8: 0xD9 acts as an unconditional return, 0xCB as an unconditional jump, and 0xDD and 0xFD as unconditional calls.
- R9: 0xE9 loads PC from HL, keeps SP and makes no stack request.
- R10: Any opcode outside the above sets PC to opcode address + 1, keeps SP, makes no stack request and reports 0 extra cycles.
- R11: While the strobe is low, `pc_q` and `sp_q` hold and both stack request outputs stay low.
- R12: SP arithmetic wraps modulo 2^AW, so a push from SP 0 lands at the top of the address space and a pop from there returns SP to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Opcode strobe |
| opcode | input | 8 | Opcode being sequenced |
| operand | input | AW | Immediate address operand |
| pc_in | input | AW | Address of the opcode |
| sp_in | input | AW | Current stack pointer |
| hl_in | input | AW | HL register pair |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_p | input | 1 | Parity flag |
| flag_c | input | 1 | Carry flag |
| pop_data | input | AW | Word currently at the top of the stack |
| pc_q | output | AW | Next program counter |
| sp_q | output | AW | Next stack pointer |
| stk_wr | output | 1 | Stack write request, one cycle |
| stk_rd | output | 1 | Stack read request, one cycle |
| stk_addr | output | AW | Stack address for the request |
| stk_wdata | output | AW | Word to push |
| extra_cyc | output | CYC_W | Cycles added beyond the base count |

## Verification
The bench uses the default parameters: a 16-bit address width, a 4-bit cycle field and a taken penalty of 6. With 16 bits, stack-pointer wrap at 0x0000/0xFFFE and byte order across a full word can be checked against a sparse stack model. The full condition matrix is swept: every condition code against all sixteen flag combinations. Calls and returns are chained through the modelled stack, so a return has to recover the address that the call pushed.

// File: rtl/branch_seq.sv
module branch_seq #(
  parameter int AW          = 16,
  parameter int CYC_W       = 4,
  parameter int TAKEN_EXTRA = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [7:0]       opcode,
  input  logic [AW-1:0]    operand,
  input  logic [AW-1:0]    pc_in,
  input  logic [AW-1:0]    sp_in,
  input  logic [AW-1:0]    hl_in,
  input  logic             flag_s,
  input  logic             flag_z,
  input  logic             flag_p,
  input  logic             flag_c,
  input  logic [AW-1:0]    pop_data,
  output logic [AW-1:0]    pc_q,
  output logic [AW-1:0]    sp_q,
  output logic             stk_wr,
  output logic             stk_rd,
  output logic [AW-1:0]    stk_addr,
  output logic [AW-1:0]    stk_wdata,
  output logic [CYC_W-1:0] extra_cyc
);

  localparam logic [AW-1:0]    ONE   = AW'(1);
  localparam logic [AW-1:0]    TWO   = AW'(2);
  localparam logic [AW-1:0]    THREE = AW'(3);
  localparam logic [CYC_W-1:0] PEN   = CYC_W'(TAKEN_EXTRA);

  wire [2:0] ccc      = opcode[5:3];
  wire       grp_hi   = opcode[7:6] == 2'b11;
  wire       is_jcond = grp_hi && opcode[2:0] == 3'b010;
  wire       is_ccond = grp_hi && opcode[2:0] == 3'b100;
  wire       is_rcond = grp_hi && opcode[2:0] == 3'b000;
  wire       is_rst   = grp_hi && opcode[2:0] == 3'b111;
  wire       is_jmp   = opcode == 8'hC3 || opcode == 8'hCB;
  wire       is_call  = opcode == 8'hCD || opcode == 8'hDD || opcode == 8'hFD;
  wire       is_ret   = opcode == 8'hC9 || opcode == 8'hD9;
  wire       is_pchl  = opcode == 8'hE9;

  logic flag_pick;
  always_comb begin
    case (ccc[2:1])
      2'd0:    flag_pick = flag_z;
      2'd1:    flag_pick = flag_c;
      2'd2:    flag_pick = flag_p;
      default: flag_pick = flag_s;
    endcase
  end
  wire taken = flag_pick == ccc[0];

  wire [AW-1:0] pc_seq  = pc_in + ONE;
  wire [AW-1:0] pc_skip = pc_in + THREE;
  wire [AW-1:0] sp_dec  = sp_in - TWO;
  wire [AW-1:0] sp_inc  = sp_in + TWO;

  logic [AW-1:0]    pc_n, sp_n, addr_n, wdata_n;
  logic             wr_n, rd_n;
  logic [CYC_W-1:0] extra_n;

  always_comb begin
    pc_n    = pc_seq;
    sp_n    = sp_in;
    addr_n  = '0;
    wdata_n = '0;
    wr_n    = 1'b0;
    rd_n    = 1'b0;
    extra_n = '0;
    if (is_jmp) begin
      pc_n = operand;
    end else if (is_jcond) begin
      pc_n = taken ? operand : pc_skip;
    end else if (is_call || (is_ccond && taken)) begin
      pc_n    = operand;
      sp_n    = sp_dec;
      addr_n  = sp_dec;
      wdata_n = pc_skip;
      wr_n    = 1'b1;
      if (is_ccond) extra_n = PEN;
    end else if (is_ccond) begin
      pc_n = pc_skip;
    end else if (is_ret || (is_rcond && taken)) begin
      pc_n   = pop_data;
      sp_n   = sp_inc;
      addr_n = sp_in;
      rd_n   = 1'b1;
      if (is_rcond) extra_n = PEN;
    end else if (is_rst) begin
      pc_n    = AW'(opcode & 8'h38);
      sp_n    = sp_dec;
      addr_n  = sp_dec;
      wdata_n = pc_seq;
      wr_n    = 1'b1;
    end else if (is_pchl) begin
      pc_n = hl_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      sp_q      <= '0;
      stk_wr    <= 1'b0;
      stk_rd    <= 1'b0;
      stk_addr  <= '0;
      stk_wdata <= '0;
      extra_cyc <= '0;
    end else if (valid) begin
      pc_q      <= pc_n;
      sp_q      <= sp_n;
      stk_wr    <= wr_n;
      stk_rd    <= rd_n;
      stk_addr  <= addr_n;
      stk_wdata <= wdata_n;
      extra_cyc <= extra_n;
    end else begin
      stk_wr    <= 1'b0;
      stk_rd    <= 1'b0;
      extra_cyc <= '0;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pc_q == '0 && sp_q == '0 && !stk_wr && !stk_rd && extra_cyc == '0));

  assert_one_request_R5: assert property (@(posedge clk) disable iff (rst)
    !(stk_wr && stk_rd));

  assert_penalty_needs_stack_R4: assert property (@(posedge clk) disable iff (rst)
    extra_cyc != '0 |-> (stk_wr || stk_rd));

  assert_call_push_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && opcode == 8'hCD) |=> (stk_wr && sp_q == $past(sp_in) - TWO
                                    && stk_wdata == $past(pc_in) + THREE
                                    && pc_q == $past(operand)));

  assert_ret_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && opcode == 8'hC9) |=> (stk_rd && pc_q == $past(pop_data)
                                    && sp_q == $past(sp_in) + TWO));

  assert_pchl_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && opcode == 8'hE9) |=> (pc_q == $past(hl_in) && sp_q == $past(sp_in)
                                    && !stk_wr && !stk_rd));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!valid && !$past(rst)) |=> ($stable(pc_q) && $stable(sp_q) && !stk_wr && !stk_rd));

endmodule

// File: tb/branch_seq_tb.sv
module branch_seq_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid;
  logic [7:0]  opcode;
  logic [15:0] operand, pc_in, sp_in, hl_in, pop_data;
  logic        flag_s, flag_z, flag_p, flag_c;
  logic [15:0] pc_q, sp_q, stk_addr, stk_wdata;
  logic        stk_wr, stk_rd;
  logic [3:0]  extra_cyc;

  int total = 0;
  int bad = 0;
  logic [7:0] mem [int];
  logic [15:0] cur_pc, cur_sp;

  always #4 clk = ~clk;

  branch_seq u_dut (
    .clk(clk), .rst(rst), .valid(valid), .opcode(opcode), .operand(operand),
    .pc_in(pc_in), .sp_in(sp_in), .hl_in(hl_in),
    .flag_s(flag_s), .flag_z(flag_z), .flag_p(flag_p), .flag_c(flag_c),
    .pop_data(pop_data), .pc_q(pc_q), .sp_q(sp_q), .stk_wr(stk_wr),
    .stk_rd(stk_rd), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .extra_cyc(extra_cyc)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  function automatic logic cond_ok(logic [2:0] c, logic [3:0] f);
    case (c)
      3'd0: return !f[2];
      3'd1: return  f[2];
      3'd2: return !f[0];
      3'd3: return  f[0];
      3'd4: return !f[1];
      3'd5: return  f[1];
      3'd6: return !f[3];
      default: return f[3];
    endcase
  endfunction

  // fl = {s, z, p, c}
  task automatic issue(logic [7:0] op, logic [15:0] opnd, logic [15:0] hl, logic [3:0] fl);
    @(negedge clk);
    valid = 1'b1; opcode = op; operand = opnd; hl_in = hl;
    {flag_s, flag_z, flag_p, flag_c} = fl;
    pc_in = cur_pc; sp_in = cur_sp;
    pop_data = {rdb(cur_sp + 16'd1), rdb(cur_sp)};
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    if (stk_wr) begin
      mem[int'(stk_addr)] = stk_wdata[7:0];
      mem[int'(stk_addr + 16'd1)] = stk_wdata[15:8];
    end
    cur_pc = pc_q; cur_sp = sp_q;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; valid = 1'b1; opcode = 8'hCD; operand = 16'h1234;
    pc_in = 16'h4000; sp_in = 16'h5000;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", pc_q, 0); chk("R1 sp", sp_q, 0);
    chk("R1 wr", stk_wr, 0); chk("R1 rd", stk_rd, 0); chk("R1 extra", extra_cyc, 0);
    rst = 1'b0; valid = 1'b0;
  endtask

  task automatic t_cond_jump;
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic t;
        t = cond_ok(3'(c), 4'(f));
        cur_pc = 16'h1000; cur_sp = 16'h6000;
        issue({2'b11, 3'(c), 3'b010}, 16'h2000 + 16'(c), 16'h0, 4'(f));
        chk("R2/R3 jcond pc", pc_q, t ? 16'h2000 + 16'(c) : 16'h1003);
        chk("R3 jcond sp", sp_q, 16'h6000);
        chk("R3 jcond wr", stk_wr, 0);
        chk("R4 jcond extra", extra_cyc, 0);
      end
    end
  endtask

  task automatic t_cond_call;
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 2; k++) begin
        logic [3:0] f;
        logic t;
        f = (k == 0) ? 4'h0 : 4'hF;
        t = cond_ok(3'(c), f);
        cur_pc = 16'h2100; cur_sp = 16'h7000;
        issue({2'b11, 3'(c), 3'b100}, 16'h3300, 16'h0, f);
        chk("R3/R5 ccall pc", pc_q, t ? 16'h3300 : 16'h2103);
        chk("R5 ccall sp", sp_q, t ? 16'h6FFE : 16'h7000);
        chk("R5 ccall wr", stk_wr, 32'(t));
        if (t) chk("R5 ccall data", stk_wdata, 16'h2103);
        chk("R4 ccall extra", extra_cyc, t ? 6 : 0);
      end
    end
  endtask

  task automatic t_cond_ret;
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 2; k++) begin
        logic [3:0] f;
        logic t;
        f = (k == 0) ? 4'h0 : 4'hF;
        t = cond_ok(3'(c), f);
        mem[16'h5000] = 8'h34; mem[16'h5001] = 8'hA2;
        cur_pc = 16'h0400; cur_sp = 16'h5000;
        issue({2'b11, 3'(c), 3'b000}, 16'h0, 16'h0, f);
        chk("R6 cret pc", pc_q, t ? 16'hA234 : 16'h0401);
        chk("R6 cret sp", sp_q, t ? 16'h5002 : 16'h5000);
        chk("R6 cret rd", stk_rd, 32'(t));
        if (t) chk("R6 cret addr", stk_addr, 16'h5000);
        chk("R4 cret extra", extra_cyc, t ? 6 : 0);
      end
    end
  endtask

  task automatic t_call_ret;
    cur_pc = 16'h1234; cur_sp = 16'h8000;
    issue(8'hCD, 16'h4567, 16'h0, 4'h0);
    chk("R5 call pc", pc_q, 16'h4567);
    chk("R5 call sp", sp_q, 16'h7FFE);
    chk("R5 low byte", rdb(16'h7FFE), 8'h37);
    chk("R5 high byte", rdb(16'h7FFF), 8'h12);
    chk("R4 call extra", extra_cyc, 0);
    issue(8'hC9, 16'h0, 16'h0, 4'h0);
    chk("R6 ret pc", pc_q, 16'h1237);
    chk("R6 ret sp", sp_q, 16'h8000);
    chk("R4 ret extra", extra_cyc, 0);
  endtask

  task automatic t_restart;
    for (int n = 0; n < 8; n++) begin
      cur_pc = 16'h3000 + 16'(n * 16); cur_sp = 16'h9000;
      issue({2'b11, 3'(n), 3'b111}, 16'hFFFF, 16'h0, 4'h0);
      chk("R7 rst pc", pc_q, 16'(n * 8));
      chk("R7 rst sp", sp_q, 16'h8FFE);
      chk("R7 rst data", stk_wdata, 16'h3001 + 16'(n * 16));
      chk("R7 rst wr", stk_wr, 1);
    end
  endtask

  task automatic t_alias;
    cur_pc = 16'h0500; cur_sp = 16'hA000;
    issue(8'hDD, 16'h6000, 16'h0, 4'h0);
    chk("R8 DD pc", pc_q, 16'h6000);
    chk("R8 DD push", {rdb(16'h9FFF), rdb(16'h9FFE)}, 16'h0503);
    issue(8'hD9, 16'h0, 16'h0, 4'h0);
    chk("R8 D9 pc", pc_q, 16'h0503);
    chk("R8 D9 sp", sp_q, 16'hA000);
    issue(8'hFD, 16'h7000, 16'h0, 4'h0);
    chk("R8 FD pc", pc_q, 16'h7000);
    chk("R8 FD sp", sp_q, 16'h9FFE);
    issue(8'hCB, 16'h1357, 16'h0, 4'h0);
    chk("R8 CB pc", pc_q, 16'h1357);
    chk("R8 CB sp", sp_q, 16'h9FFE);
    chk("R8 CB wr", stk_wr, 0);
  endtask

  task automatic t_pchl;
    cur_pc = 16'h0100; cur_sp = 16'h0200;
    issue(8'hE9, 16'h1111, 16'hBEEF, 4'hF);
    chk("R9 pc", pc_q, 16'hBEEF);
    chk("R9 sp", sp_q, 16'h0200);
    chk("R9 wr", stk_wr, 0);
    chk("R9 rd", stk_rd, 0);
  endtask

  task automatic t_other;
    logic [7:0] ops [4] = '{8'h00, 8'h3E, 8'h76, 8'hED};
    foreach (ops[i]) begin
      cur_pc = 16'h2222; cur_sp = 16'h3333;
      issue(ops[i], 16'h4444, 16'h5555, 4'hF);
      chk("R10 pc", pc_q, 16'h2223);
      chk("R10 sp", sp_q, 16'h3333);
      chk("R10 req", {stk_wr, stk_rd}, 0);
      chk("R10 extra", extra_cyc, 0);
    end
  endtask

  task automatic t_idle;
    cur_pc = 16'h0700; cur_sp = 16'h0800;
    issue(8'hCD, 16'h0900, 16'h0, 4'h0);
    @(negedge clk);
    opcode = 8'hE9; hl_in = 16'hDEAD; pc_in = 16'h1; sp_in = 16'h2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 pc", pc_q, 16'h0900);
    chk("R11 sp", sp_q, 16'h07FE);
    chk("R11 wr", stk_wr, 0);
    chk("R11 rd", stk_rd, 0);
  endtask

  task automatic t_wrap;
    cur_pc = 16'h0010; cur_sp = 16'h0000;
    issue(8'hCD, 16'h0020, 16'h0, 4'h0);
    chk("R12 push sp", sp_q, 16'hFFFE);
    chk("R12 push addr", stk_addr, 16'hFFFE);
    chk("R12 word", {rdb(16'hFFFF), rdb(16'hFFFE)}, 16'h0013);
    issue(8'hC9, 16'h0, 16'h0, 4'h0);
    chk("R12 pop sp", sp_q, 16'h0000);
    chk("R12 pop pc", pc_q, 16'h0013);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; valid = 1'b0; opcode = 8'h00; operand = '0; pc_in = '0;
    sp_in = '0; hl_in = '0; pop_data = '0;
    {flag_s, flag_z, flag_p, flag_c} = 4'h0;
    cur_pc = '0; cur_sp = '0;
    repeat (2) @(posedge clk);
    t_reset;
    t_cond_jump;
    t_cond_call;
    t_cond_ret;
    t_call_ret;
    t_restart;
    t_alias;
    t_pchl;
    t_other;
    t_idle;
    t_wrap;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule